// File: doc/BRIEF.md
# Transmit Cell Channel Scheduler

This block builds the transmit cell stream for a group of constant-bit-rate channels. It steps through the channels one by one. For each channel it looks at a single "payload ready" bit held in an external flag store. A channel whose bit is clear costs one clock and is passed over. A channel whose bit is set starts a fixed sequence:

1. A header request goes to an external header generator. The request carries the channel number and that channel's 3-bit sequence count.
2. The header byte that comes back is sent on the byte-wide output.
3. The channel's 47 payload bytes are read from an external synchronous payload memory and sent after the header.
4. The flag bit is cleared and the channel's sequence count advances.

The scanning pointer then moves to the next channel and wraps after the last one.

The output is a byte stream with valid/ready flow control and a marker on the last byte of each 48-byte cell. The memory holding the payload bytes and the logic that puts finished cells on the line are outside this block.

Top module: `txcell_sched`

## Requirements
- R1: While reset is asserted, and right after it is released, `cell_valid`, `hdr_req` and `flag_clr` are 0 and `flag_addr` is 0.
- R2: When the scheduler is scanning, `flag_addr` shows the channel under test. If `flag_rdy` is 0, `flag_addr` moves to the next channel on the following cycle, so each idle channel costs exactly one cycle.
- R3: The channel pointer goes from NUM_CH-1 to 0.
- R4: For a channel with `flag_rdy`=1, `hdr_req` is raised with `hdr_ch` equal to the channel. `hdr_req` and `hdr_ch` stay steady until `hdr_ack`. The `hdr_byte` present with `hdr_ack` becomes the first byte of the cell.
- R5: The header byte is followed by 47 payload bytes. Byte k (0..46) of channel c is read from payload address c*47+k, and the bytes go out in increasing k.
- R6: `cell_last` is 1 on the 48th byte of a cell and 0 on every other byte. Every cell has exactly 48 bytes.
- R7: While `cell_valid`=1 and `cell_ready`=0, `cell_valid`, `cell_data` and `cell_last` keep their values. No byte is lost or sent twice.
- R8: `flag_clr` pulses for one cycle, in the cycle after the last byte is accepted, with `flag_addr` equal to the channel just served. It is never raised at any other time.
- R9: Each channel has its own 3-bit sequence count, which is 0 after reset. The count is presented on `hdr_sc` with the request and goes up by 1 after each cell of that channel, wrapping from 7 to 0. Other channels' counts are unaffected.
- R10: Channels whose flag is set are served in ascending cyclic order from the pointer position, each once per set flag. Channels whose flag is clear produce no cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_addr | output | CH_W | Channel whose ready flag is read or cleared |
| flag_rdy | input | 1 | Ready flag of `flag_addr`, combinational read |
| flag_clr | output | 1 | Clear the flag at `flag_addr` |
| pay_addr | output | ADDR_W | Payload memory read address (one-cycle read latency) |
| pay_data | input | 8 | Payload memory read data |
| hdr_req | output | 1 | Header request |
| hdr_ch | output | CH_W | Channel of the header request |
| hdr_sc | output | SC_W | Sequence count of that channel |
| hdr_ack | input | 1 | Header ready |
| hdr_byte | input | 8 | Header byte, valid with `hdr_ack` |
| cell_valid | output | 1 | Output byte valid |
| cell_ready | input | 1 | Output byte accepted when high with valid |
| cell_data | output | 8 | Output byte |
| cell_last | output | 1 | Marks the final byte of a cell |

## Verification
The assertions make three assumptions about the inputs:
- The flag store answers in the same cycle, and a flag only rises through an external write.
- The payload memory returns the data of the address it saw at the previous clock edge.
- The header generator raises `hdr_ack` for one cycle only while a request is pending.

The bench models all three agents in exactly this way. Its header model acknowledges one cycle after the request and drops the acknowledge once it is seen. Its flag store sets bits only while the block is idle between test phases and clears them only on `flag_clr`. Its memory returns an arithmetic function of the address one edge later.

// File: rtl/txs_pkg.sv
package txs_pkg;

  typedef enum logic [2:0] {
    ST_SCAN,
    ST_HREQ,
    ST_SEND,
    ST_FETCH,
    ST_LOAD,
    ST_DONE
  } txs_state_e;

  // Next channel with wrap after the highest channel
  function automatic int unsigned wrap_next(int unsigned cur, int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

  // Payload memory layout: one contiguous block per channel
  function automatic int unsigned byte_addr(int unsigned ch, int unsigned k,
                                            int unsigned pay);
    return ch * pay + k;
  endfunction

endpackage

// File: rtl/txs_chan_ptr.sv
module txs_chan_ptr #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  output logic [CH_W-1:0] ch
);
  import txs_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) ch <= '0;
    else if (adv) ch <= CH_W'(wrap_next(int'(ch), NUM_CH));
  end
endmodule

// File: rtl/txs_seq_bank.sv
module txs_seq_bank #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int SC_W   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc,
  input  logic [CH_W-1:0] ch,
  output logic [SC_W-1:0] sc
);
  logic [SC_W-1:0] sc_r [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n) sc_r[i] <= '0;
      else if (inc && (ch == CH_W'(i))) sc_r[i] <= sc_r[i] + 1'b1;
    end
  end

  assign sc = sc_r[ch];
endmodule

// File: rtl/txs_byte_ctr.sv
module txs_byte_ctr #(
  parameter int PAY_BYTES = 47,
  parameter int K_W       = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           step,
  output logic [K_W-1:0] k,
  output logic           is_last
);
  always_ff @(posedge clk) begin
    if (!rst_n)    k <= '0;
    else if (clr)  k <= '0;
    else if (step) k <= k + 1'b1;
  end

  assign is_last = (k == K_W'(PAY_BYTES - 1));
endmodule

// File: rtl/txs_out_reg.sv
module txs_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         last_in,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout,
  output logic         last
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
      last  <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
      last  <= last_in;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/txcell_sched.sv
module txcell_sched #(
  parameter int NUM_CH    = 4,
  parameter int PAY_BYTES = 47,
  parameter int SC_W      = 3,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W   = $clog2(NUM_CH * PAY_BYTES),
  localparam int K_W      = $clog2(PAY_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [CH_W-1:0]   flag_addr,
  input  logic              flag_rdy,
  output logic              flag_clr,
  output logic [ADDR_W-1:0] pay_addr,
  input  logic [7:0]        pay_data,
  output logic              hdr_req,
  output logic [CH_W-1:0]   hdr_ch,
  output logic [SC_W-1:0]   hdr_sc,
  input  logic              hdr_ack,
  input  logic [7:0]        hdr_byte,
  output logic              cell_valid,
  input  logic              cell_ready,
  output logic [7:0]        cell_data,
  output logic              cell_last
);
  import txs_pkg::*;

  txs_state_e st, st_nx;
  logic [CH_W-1:0] ch;
  logic [K_W-1:0]  k;
  logic            k_last;

  // Named internal events
  logic scan_skip, scan_hit, hdr_take, accept, cell_done, pay_load, cell_end;
  logic       out_load, out_last_in;
  logic [7:0] out_din;

  assign scan_skip = (st == ST_SCAN) && !flag_rdy;
  assign scan_hit  = (st == ST_SCAN) && flag_rdy;
  assign hdr_take  = (st == ST_HREQ) && hdr_ack;
  assign accept    = (st == ST_SEND) && cell_valid && cell_ready;
  assign cell_done = accept && cell_last;
  assign pay_load  = (st == ST_LOAD);
  assign cell_end  = (st == ST_DONE);

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_SCAN:  if (scan_hit) st_nx = ST_HREQ;
      ST_HREQ:  if (hdr_take) st_nx = ST_SEND;
      ST_SEND:  if (accept) st_nx = cell_last ? ST_DONE : ST_FETCH;
      ST_FETCH: st_nx = ST_LOAD;
      ST_LOAD:  st_nx = ST_SEND;
      ST_DONE:  st_nx = ST_SCAN;
      default:  st_nx = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_SCAN;
    else        st <= st_nx;
  end

  txs_chan_ptr #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ptr (
    .clk (clk), .rst_n (rst_n), .adv (scan_skip || cell_end), .ch (ch)
  );

  txs_seq_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W), .SC_W(SC_W)) u_seq (
    .clk (clk), .rst_n (rst_n), .inc (cell_end), .ch (ch), .sc (hdr_sc)
  );

  txs_byte_ctr #(.PAY_BYTES(PAY_BYTES), .K_W(K_W)) u_kctr (
    .clk (clk), .rst_n (rst_n), .clr (hdr_take), .step (pay_load),
    .k (k), .is_last (k_last)
  );

  assign out_load    = hdr_take || pay_load;
  assign out_din     = hdr_take ? hdr_byte : pay_data;
  assign out_last_in = pay_load && k_last;

  txs_out_reg #(.W(8)) u_out (
    .clk (clk), .rst_n (rst_n), .load (out_load), .din (out_din),
    .last_in (out_last_in), .ready (cell_ready), .valid (cell_valid),
    .dout (cell_data), .last (cell_last)
  );

  assign flag_addr = ch;
  assign flag_clr  = cell_end;
  assign hdr_req   = (st == ST_HREQ);
  assign hdr_ch    = ch;
  assign pay_addr  = ADDR_W'(byte_addr(int'(ch), int'(k), PAY_BYTES));
endmodule

// File: rtl/txcell_sched_chk.sv
module txcell_sched_chk #(
  parameter int NUM_CH    = 4,
  parameter int PAY_BYTES = 47,
  parameter int CH_W      = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cell_valid,
  input logic            cell_ready,
  input logic [7:0]      cell_data,
  input logic            cell_last,
  input logic            hdr_req,
  input logic            hdr_ack,
  input logic [CH_W-1:0] hdr_ch,
  input logic            flag_clr,
  input logic [CH_W-1:0] flag_addr,
  input logic            scan_skip
);
  logic [7:0] nbytes;
  always_ff @(posedge clk) begin
    if (!rst_n) nbytes <= '0;
    else if (cell_valid && cell_ready) nbytes <= cell_last ? 8'd0 : nbytes + 8'd1;
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid && !cell_ready |=> cell_valid && $stable(cell_data) && $stable(cell_last));

  // R4
  hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_req && !hdr_ack |=> hdr_req && $stable(hdr_ch));

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_req && cell_valid));

  // R6
  last_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid && cell_ready && cell_last |-> nbytes == 8'(PAY_BYTES));

  // R6
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid && cell_ready && !cell_last |-> nbytes < 8'(PAY_BYTES));

  // R8
  clr_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |-> $past(cell_valid && cell_ready && cell_last));

  // R2
  skip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_skip |=> flag_addr == (($past(flag_addr) == CH_W'(NUM_CH - 1)) ? '0
                                 : $past(flag_addr) + 1'b1));
endmodule

bind txcell_sched txcell_sched_chk #(
  .NUM_CH (NUM_CH), .PAY_BYTES (PAY_BYTES), .CH_W (CH_W)
) u_chk (
  .clk (clk), .rst_n (rst_n), .cell_valid (cell_valid), .cell_ready (cell_ready),
  .cell_data (cell_data), .cell_last (cell_last), .hdr_req (hdr_req),
  .hdr_ack (hdr_ack), .hdr_ch (hdr_ch), .flag_clr (flag_clr),
  .flag_addr (flag_addr), .scan_skip (scan_skip)
);

// File: tb/sim_txcell_sched.sv
`timescale 1ns/1ps
module sim_txcell_sched;
  localparam int NCH = 5;
  localparam int PB  = 47;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic [2:0] flag_addr;
  logic       flag_rdy, flag_clr;
  logic [7:0] pay_addr, pay_data;
  logic       hdr_req, hdr_ack;
  logic [2:0] hdr_ch, hdr_sc;
  logic [7:0] hdr_byte;
  logic       cell_valid, cell_ready, cell_last;
  logic [7:0] cell_data;

  txcell_sched #(.NUM_CH(NCH), .PAY_BYTES(PB), .SC_W(3)) u0 (.*);

  int n_chk = 0, n_bad = 0;
  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Agent models
  logic [NCH-1:0] flags = '0, set_mask = '0;
  assign flag_rdy = (int'(flag_addr) < NCH) ? flags[flag_addr] : 1'b0;
  always @(posedge clk) begin
    flags <= (flags | set_mask) & ~((flag_clr && int'(flag_addr) < NCH) ?
                                    (NCH'(1) << flag_addr) : '0);
    hdr_ack  <= rst_n && hdr_req && !hdr_ack;
    hdr_byte <= {1'b1, hdr_sc, 1'b0, hdr_ch};
    pay_data <= 8'((int'(pay_addr) * 7 + 3));
  end

  function automatic logic [7:0] exp_pay(int c, int k);
    return 8'(((c * PB + k) * 7 + 3));
  endfunction

  // Output monitor and ready pattern
  int mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] buf_d [48];
  logic       buf_l [48];
  int nb = 0, last_ch = -1;
  bit just_done = 0;
  int sc_exp [NCH];
  int rx_q [$];
  bit stalled = 0;
  logic [7:0] st_d;
  logic st_l;

  initial for (int i = 0; i < NCH; i++) sc_exp[i] = 0;

  task automatic close_cell();
    int c;
    bit pay_ok, last_ok;
    c = int'(buf_d[0][2:0]);
    chk(nb == 48, "R6", "cell length", nb, 48);
    chk(c < NCH && buf_d[0] == {1'b1, 3'(sc_exp[c % NCH]), 1'b0, 3'(c)},
        "R4/R9", "header byte", int'(buf_d[0]),
        int'({1'b1, 3'(sc_exp[c % NCH]), 1'b0, 3'(c)}));
    pay_ok = 1; last_ok = 1;
    for (int k = 0; k < 47 && k + 1 < nb; k++)
      if (buf_d[k+1] != exp_pay(c, k)) pay_ok = 0;
    for (int j = 0; j < nb; j++)
      if (buf_l[j] != (j == 47)) last_ok = 0;
    chk(pay_ok, "R5/R7", "payload bytes ok", int'(pay_ok), 1);
    chk(last_ok, "R6", "last marker only on byte 48", int'(last_ok), 1);
    sc_exp[c % NCH] = (sc_exp[c % NCH] + 1) % 8;
    rx_q.push_back(c);
    last_ch = c; just_done = 1; nb = 0;
  endtask

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (mode)
      0: cell_ready = 1'b1;
      1: cell_ready = lfsr[0];
      default: cell_ready = (lfsr[1:0] == 2'b00);
    endcase
    if (rst_n) begin
      if (stalled)
        chk(cell_valid && cell_data == st_d && cell_last == st_l,
            "R7", "held during stall", int'(cell_data), int'(st_d));
      stalled = cell_valid && !cell_ready;
      st_d = cell_data; st_l = cell_last;
      if (flag_clr) begin
        chk(just_done && int'(flag_addr) == last_ch, "R8", "clear channel",
            int'(flag_addr), last_ch);
        just_done = 0;
      end
      if (cell_valid && cell_ready) begin
        if (nb < 48) begin buf_d[nb] = cell_data; buf_l[nb] = cell_last; end
        nb++;
        if (cell_last || nb == 48) close_cell();
      end
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic run_phase(logic [NCH-1:0] s, int m, string tag);
    int first, desc, t;
    logic [NCH-1:0] got;
    bit ok;
    mode = m;
    rx_q.delete();
    @(negedge clk); set_mask = s;
    @(negedge clk); set_mask = '0;
    t = 0;
    while ((flags != 0 || cell_valid || nb != 0) && t < 30000) begin
      @(negedge clk); t++;
    end
    repeat (3) @(negedge clk);
    chk(flags == 0, "R8", {tag, " flags cleared"}, int'(flags), 0);
    got = '0; desc = 0; ok = 1;
    foreach (rx_q[i]) begin
      if (got[rx_q[i]]) ok = 0;
      got[rx_q[i]] = 1'b1;
      if (i > 0 && rx_q[i] < rx_q[i-1]) desc++;
    end
    first = (rx_q.size() > 0) ? rx_q[0] : 0;
    if (desc > 1 || (desc == 1 && rx_q[rx_q.size()-1] >= first)) ok = 0;
    chk(ok && got == s, "R10", {tag, " served set/order"}, int'(got), int'(s));
  endtask

  initial begin
    int prev;
    cell_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!cell_valid && !hdr_req && !flag_clr && flag_addr == 0, "R1",
        "outputs in reset", int'(flag_addr), 0);
    rst_n = 1;
    chk(!cell_valid && !hdr_req && flag_addr == 0, "R1", "after release",
        int'(flag_addr), 0);
    // R2/R3 idle scan sweep
    prev = int'(flag_addr);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(int'(flag_addr) == (prev + 1) % NCH, (prev == NCH - 1) ? "R3" : "R2",
          "scan step", int'(flag_addr), (prev + 1) % NCH);
      prev = int'(flag_addr);
    end
    run_phase(5'b11111, 0, "all ch ready=1");
    run_phase(5'b01010, 1, "ch1,3 random ready");
    run_phase(5'b10101, 2, "ch0,2,4 slow ready");
    // R9 wrap: channel 2 repeatedly (sc goes past 7)
    for (int r = 0; r < 10; r++) run_phase(5'b00100, 1, "ch2 repeat");
    chk(sc_exp[2] == 4, "R9", "seq count wrapped", sc_exp[2], 4);
    chk(sc_exp[1] == 2 && sc_exp[0] == 2, "R9", "others independent",
        sc_exp[1], 2);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule